// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Checks

This block holds recently used address translations for a processor. Each slot pairs a virtual page number and the identifier of the process that owns it with a physical page number. Each slot also carries a set of attribute bits: present, writable, executable, user-accessible, no-cache, accessed and dirty. Every slot is compared against a lookup request in the same cycle. The matching slot's attributes are weighed against the access kind (load, store or instruction fetch) and the privilege of the requester. One cycle later the block reports one of four outcomes: a clean hit, a miss, a not-present page fault or a protection fault.

A page walker outside the block installs translations through the fill port. The walker is started when a miss is reported. The operating system side removes stale translations through the invalidate port, either one page of one process or every page of a process. The block keeps the accessed and dirty attributes up to date on successful hits and reports them with the result, so the owner can decide when to write them back.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup presented with `lk_valid` high yields its result one clock later with `rs_valid` high. Without a lookup, `rs_valid`, `rs_hit` are low and `rs_fault` is 0 (none). After reset, `rs_valid` is low. The slot count `ENTRIES` is a parameter that must lie between 32 and 256.
- R2: A slot matches only when it is valid and both its page number and its process identifier equal the request. The same page number under another process identifier is a miss.
- R3: When no slot matches, `rs_fault` = 1 (miss), `rs_hit` = 0, `rs_ppn` = 0 and `rs_nocache` = 0.
- R4: A match on a slot whose present bit is clear gives `rs_fault` = 2 (page fault), and `rs_hit` = 0. This outcome takes priority over any protection check.
- R5: On a present slot, any of the following gives `rs_fault` = 3 (protection) with `rs_hit` = 0: a store (`lk_kind` = 1) to a non-writable slot, a fetch (`lk_kind` = 2) from a non-executable slot, or a user access (`lk_user` = 1) to a slot that is not user-accessible. A load is `lk_kind` = 0.
- R6: On a clean hit, `rs_hit` = 1, `rs_fault` = 0, `rs_ppn` is the slot's physical page, and `rs_nocache` is the slot's no-cache bit.
- R7: A freshly filled slot has its accessed bit clear. A clean hit sets the bit. `rs_was_acc` reports the bit as it was before the access. A faulting access leaves the bit unchanged.
- R8: A freshly filled slot is clean. A store hit marks the slot dirty. `rs_dirty` reports the dirty bit after the access.
- R9: A fill whose page and process already occupy a slot overwrites that slot. Otherwise the fill takes the lowest-numbered invalid slot and does not move the replacement pointer.
- R10: When every slot is valid and the fill matches none, the fill replaces the slot under a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each such replacement.
- R11: An invalidate with `inv_by_pid` = 0 removes only the slot that matches both `inv_vpn` and `inv_pid`.
- R12: An invalidate with `inv_by_pid` = 1 removes every slot owned by `inv_pid`, whatever its page, and leaves other processes' slots in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Process identifier of the request |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | 1 when the request runs at user privilege |
| fl_valid | input | 1 | Install a translation |
| fl_vpn | input | VPN_W | Page number being installed |
| fl_pid | input | PID_W | Owner of the installed page |
| fl_ppn | input | PPN_W | Physical page number |
| fl_present | input | 1 | Page is resident |
| fl_writable | input | 1 | Stores allowed |
| fl_exec | input | 1 | Fetches allowed |
| fl_user | input | 1 | User privilege allowed |
| fl_nocache | input | 1 | Accesses must bypass caching |
| inv_valid | input | 1 | Invalidate request |
| inv_by_pid | input | 1 | 1 removes all slots of `inv_pid`, 0 removes one page |
| inv_vpn | input | VPN_W | Page to remove when `inv_by_pid` is 0 |
| inv_pid | input | PID_W | Process whose slots are removed |
| rs_valid | output | 1 | Result is present |
| rs_hit | output | 1 | Clean translation |
| rs_ppn | output | PPN_W | Physical page on a hit, else 0 |
| rs_nocache | output | 1 | No-cache bit of the hit slot |
| rs_was_acc | output | 1 | Accessed bit before this hit |
| rs_dirty | output | 1 | Dirty bit after this hit |
| rs_fault | output | 2 | 0 none, 1 miss, 2 page fault, 3 protection |

## Verification
The table is filled so that each of the 32 slots holds one of the 32 combinations of present, writable, executable, user and no-cache bits. Each slot is then probed with every access kind at both privileges. This separates page faults from protection faults and shows the priority between them. It also shows which attribute blocks which access, and that accessed and dirty bits move only on clean hits. Further sequences use a foreign process identifier, a refill of an existing page, both kinds of invalidate, a fill into a hole, and fills into a full table. These show matching on both keys, lowest-hole placement, and the order of the rotating replacement.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_MISS = 2'd1,
      FLT_PAGE = 2'd2,
      FLT_PROT = 2'd3
   } fault_e;

endpackage

// File: rtl/xlat_cam.sv
// Parallel tag compare: one match line per slot.
module xlat_cam #(
   parameter int N     = 32,
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic [N-1:0]            slot_v,
   input  logic [N-1:0][VPN_W-1:0] slot_vpn,
   input  logic [N-1:0][PID_W-1:0] slot_pid,
   input  logic                    use_vpn,
   input  logic [VPN_W-1:0]        key_vpn,
   input  logic [PID_W-1:0]        key_pid,
   output logic [N-1:0]            match
);
   for (genvar g = 0; g < N; g++) begin : g_line
      logic vpn_eq, pid_eq;
      assign vpn_eq   = (slot_vpn[g] == key_vpn);
      assign pid_eq   = (slot_pid[g] == key_pid);
      assign match[g] = slot_v[g] & pid_eq & (vpn_eq | ~use_vpn);
   end
endmodule

// File: rtl/xlat_pick.sv
// Lowest-index selector over a request vector.
module xlat_pick #(
   parameter int N  = 32,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            found = 1'b1;
            idx   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/xlat_perm.sv
// Attribute check for one matched slot.
module xlat_perm
   import xlat_pkg::*;
(
   input  logic       present,
   input  logic       writable,
   input  logic       exec,
   input  logic       user_ok,
   input  logic [1:0] kind,
   input  logic       user,
   output fault_e     fault
);
   logic bad_store, bad_fetch, bad_priv;

   always_comb begin
      bad_store = (kind == ACC_STORE) && !writable;
      bad_fetch = (kind == ACC_FETCH) && !exec;
      bad_priv  = user && !user_ok;
      if (!present)
         fault = FLT_PAGE;
      else if (bad_store || bad_fetch || bad_priv)
         fault = FLT_PROT;
      else
         fault = FLT_NONE;
   end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PID_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   input  logic [1:0]       lk_kind,
   input  logic             lk_user,
   input  logic             fl_valid,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [PID_W-1:0] fl_pid,
   input  logic [PPN_W-1:0] fl_ppn,
   input  logic             fl_present,
   input  logic             fl_writable,
   input  logic             fl_exec,
   input  logic             fl_user,
   input  logic             fl_nocache,
   input  logic             inv_valid,
   input  logic             inv_by_pid,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [PID_W-1:0] inv_pid,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic [PPN_W-1:0] rs_ppn,
   output logic             rs_nocache,
   output logic             rs_was_acc,
   output logic             rs_dirty,
   output logic [1:0]       rs_fault
);
   localparam int IW = $clog2(ENTRIES);
   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

   if (ENTRIES < 32 || ENTRIES > 256) begin : g_bad_entries
      $error("xlat_buffer: ENTRIES must lie in 32..256");
   end
   if (VPN_W < 1 || PPN_W < 1 || PID_W < 1) begin : g_bad_width
      $error("xlat_buffer: field widths must be positive");
   end

   // slot storage
   logic [ENTRIES-1:0]            v_q, p_q, w_q, x_q, u_q, cd_q, a_q, d_q;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PID_W-1:0] pid_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [IW-1:0]                 rr_q;

   // lookup path
   logic [ENTRIES-1:0] lk_hit_v;
   logic               lk_found;
   logic [IW-1:0]      lk_idx;
   fault_e             lk_perm;
   logic               lk_clean;

   xlat_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
      .slot_v(v_q), .slot_vpn(vpn_q), .slot_pid(pid_q),
      .use_vpn(1'b1), .key_vpn(lk_vpn), .key_pid(lk_pid), .match(lk_hit_v));

   xlat_pick #(.N(ENTRIES)) u_pick_lk (
      .req(lk_hit_v), .found(lk_found), .idx(lk_idx));

   xlat_perm u_perm (
      .present(p_q[lk_idx]), .writable(w_q[lk_idx]), .exec(x_q[lk_idx]),
      .user_ok(u_q[lk_idx]), .kind(lk_kind), .user(lk_user), .fault(lk_perm));

   assign lk_clean = lk_valid && lk_found && (lk_perm == FLT_NONE);

   // fill placement
   logic [ENTRIES-1:0] fl_hit_v;
   logic               fl_same, fl_hole;
   logic [IW-1:0]      fl_same_idx, fl_hole_idx, fl_slot;
   logic               fl_evict;

   xlat_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fl (
      .slot_v(v_q), .slot_vpn(vpn_q), .slot_pid(pid_q),
      .use_vpn(1'b1), .key_vpn(fl_vpn), .key_pid(fl_pid), .match(fl_hit_v));

   xlat_pick #(.N(ENTRIES)) u_pick_same (
      .req(fl_hit_v), .found(fl_same), .idx(fl_same_idx));

   xlat_pick #(.N(ENTRIES)) u_pick_hole (
      .req(~v_q), .found(fl_hole), .idx(fl_hole_idx));

   always_comb begin
      fl_evict = 1'b0;
      if (fl_same)
         fl_slot = fl_same_idx;
      else if (fl_hole)
         fl_slot = fl_hole_idx;
      else begin
         fl_slot  = rr_q;
         fl_evict = 1'b1;
      end
   end

   // invalidate match
   logic [ENTRIES-1:0] inv_hit_v;

   xlat_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_inv (
      .slot_v(v_q), .slot_vpn(vpn_q), .slot_pid(pid_q),
      .use_vpn(~inv_by_pid), .key_vpn(inv_vpn), .key_pid(inv_pid),
      .match(inv_hit_v));

   // slot state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= '0;  p_q <= '0;  w_q <= '0;  x_q <= '0;
         u_q   <= '0;  cd_q <= '0; a_q <= '0;  d_q <= '0;
         vpn_q <= '0;  pid_q <= '0; ppn_q <= '0;
         rr_q  <= '0;
      end else begin
         if (inv_valid)
            v_q <= v_q & ~inv_hit_v;
         if (lk_clean) begin
            a_q[lk_idx] <= 1'b1;
            if (lk_kind == ACC_STORE)
               d_q[lk_idx] <= 1'b1;
         end
         if (fl_valid) begin
            v_q[fl_slot]   <= 1'b1;
            vpn_q[fl_slot] <= fl_vpn;
            pid_q[fl_slot] <= fl_pid;
            ppn_q[fl_slot] <= fl_ppn;
            p_q[fl_slot]   <= fl_present;
            w_q[fl_slot]   <= fl_writable;
            x_q[fl_slot]   <= fl_exec;
            u_q[fl_slot]   <= fl_user;
            cd_q[fl_slot]  <= fl_nocache;
            a_q[fl_slot]   <= 1'b0;
            d_q[fl_slot]   <= 1'b0;
            if (fl_evict)
               rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
         end
      end
   end

   // registered result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid   <= 1'b0;
         rs_hit     <= 1'b0;
         rs_ppn     <= '0;
         rs_nocache <= 1'b0;
         rs_was_acc <= 1'b0;
         rs_dirty   <= 1'b0;
         rs_fault   <= FLT_NONE;
      end else begin
         rs_valid   <= lk_valid;
         rs_hit     <= lk_clean;
         rs_ppn     <= lk_clean ? ppn_q[lk_idx] : '0;
         rs_nocache <= lk_clean && cd_q[lk_idx];
         rs_was_acc <= lk_clean && a_q[lk_idx];
         rs_dirty   <= lk_clean && (d_q[lk_idx] || (lk_kind == ACC_STORE));
         if (!lk_valid)
            rs_fault <= FLT_NONE;
         else if (!lk_found)
            rs_fault <= FLT_MISS;
         else
            rs_fault <= lk_perm;
      end
   end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
   parameter int ENTRIES = 32,
   parameter int PPN_W   = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [ENTRIES-1:0] lk_hit_v,
   input logic               rs_valid,
   input logic               rs_hit,
   input logic [PPN_W-1:0]   rs_ppn,
   input logic               rs_nocache,
   input logic [1:0]         rs_fault
);
   p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);

   p_idle_no_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rs_valid && !rs_hit && rs_fault == 2'd0));

   p_miss_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_fault == 2'd1) |-> (!rs_hit && rs_ppn == '0 && !rs_nocache));

   p_fault_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_fault != 2'd0) |-> !rs_hit);

   p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_v));
endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit_v(lk_hit_v),
   .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_ppn(rs_ppn),
   .rs_nocache(rs_nocache), .rs_fault(rs_fault));

// File: tb/xlat_buffer_test.sv
`timescale 1ns/1ps
module xlat_buffer_test;
   localparam int N = 32, VW = 20, PW = 20, IDW = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic lk_valid, lk_user;
   logic [VW-1:0] lk_vpn;
   logic [IDW-1:0] lk_pid;
   logic [1:0] lk_kind;
   logic fl_valid, fl_present, fl_writable, fl_exec, fl_user, fl_nocache;
   logic [VW-1:0] fl_vpn;
   logic [IDW-1:0] fl_pid;
   logic [PW-1:0] fl_ppn;
   logic inv_valid, inv_by_pid;
   logic [VW-1:0] inv_vpn;
   logic [IDW-1:0] inv_pid;
   logic rs_valid, rs_hit, rs_nocache, rs_was_acc, rs_dirty;
   logic [PW-1:0] rs_ppn;
   logic [1:0] rs_fault;

   xlat_buffer #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .PID_W(IDW)) uut (.*);

   int checks = 0, errors = 0;
   logic m_acc [N];
   logic m_dirty [N];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fill(input int vpn, input int pid, input int ppn, input logic [4:0] f);
      fl_valid = 1; fl_vpn = VW'(vpn); fl_pid = IDW'(pid); fl_ppn = PW'(ppn);
      {fl_nocache, fl_user, fl_exec, fl_writable, fl_present} = f;
      @(posedge clk); #1;
      fl_valid = 0;
   endtask

   task automatic inval(input logic by_pid, input int vpn, input int pid);
      inv_valid = 1; inv_by_pid = by_pid; inv_vpn = VW'(vpn); inv_pid = IDW'(pid);
      @(posedge clk); #1;
      inv_valid = 0;
   endtask

   // result bundle: {valid, hit, fault, nocache, was_acc, dirty, ppn}
   task automatic look(string tag, input int vpn, input int pid, input int kind,
                       input logic user, input logic [31:0] exp);
      lk_valid = 1; lk_vpn = VW'(vpn); lk_pid = IDW'(pid);
      lk_kind = 2'(kind); lk_user = user;
      @(posedge clk); #1;
      lk_valid = 0;
      check(tag, {5'b0, rs_valid, rs_hit, rs_fault, rs_nocache, rs_was_acc, rs_dirty, rs_ppn},
            exp);
   endtask

   function automatic logic [31:0] pack_exp(logic h, logic [1:0] f, logic cd,
                                            logic a, logic d, int ppn);
      return {5'b0, 1'b1, h, f, cd, a, d, PW'(ppn)};
   endfunction

   // expected outcome for an original sweep slot (vpn i, flags = i, ppn 0x100+i)
   task automatic look_model(string tag, input int i, input int kind, input logic user);
      logic [4:0] f;
      logic [31:0] e;
      f = 5'(i);
      if (!f[0])
         e = pack_exp(0, 2'd2, 0, 0, 0, 0);
      else if ((kind == 1 && !f[1]) || (kind == 2 && !f[2]) || (user && !f[3]))
         e = pack_exp(0, 2'd3, 0, 0, 0, 0);
      else begin
         e = pack_exp(1, 2'd0, f[4], m_acc[i], m_dirty[i] | (kind == 1), 'h100 + i);
         m_acc[i] = 1;
         if (kind == 1) m_dirty[i] = 1;
      end
      look(tag, i, 1, kind, user, e);
   endtask

   initial begin
      rst_n = 0; lk_valid = 0; lk_vpn = 0; lk_pid = 0; lk_kind = 0; lk_user = 0;
      fl_valid = 0; fl_vpn = 0; fl_pid = 0; fl_ppn = 0;
      {fl_present, fl_writable, fl_exec, fl_user, fl_nocache} = '0;
      inv_valid = 0; inv_by_pid = 0; inv_vpn = 0; inv_pid = 0;
      for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_dirty[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check("R1 reset result idle", {30'b0, rs_valid, rs_hit}, 32'd0);

      // one slot per attribute combination
      for (int i = 0; i < N; i++) fill(i, 1, 'h100 + i, 5'(i));

      // sweep every slot x access kind x privilege (R4 R5 R6 R7 R8)
      for (int i = 0; i < N; i++)
         for (int u = 0; u < 2; u++)
            for (int k = 0; k < 3; k++)
               look_model("R4/R5/R6 R7 R8 sweep", i, k, 1'(u));

      // second store sees dirty already set, accessed already set (R7 R8)
      look_model("R7 R8 repeat store", 31, 1, 0);

      // foreign process id misses (R2 R3)
      look("R2 R3 foreign pid", 5, 2, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));

      // refill an existing page overwrites, fresh A/D (R9 R7)
      fill(31, 1, 'h3FF, 5'b01111);
      look("R9 refill overwrite", 31, 1, 0, 0, pack_exp(1, 0, 0, 0, 0, 'h3FF));
      look("R7 refill accessed", 31, 1, 1, 1, pack_exp(1, 0, 0, 1, 1, 'h3FF));

      // single invalidate (R11)
      inval(0, 3, 1);
      look("R11 removed page", 3, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look_model("R11 neighbour kept", 5, 0, 0);

      // fill goes into the hole, pointer stays at slot 0 (R9)
      fill(200, 1, 'h2C8, 5'b01111);
      look("R9 hole fill", 200, 1, 0, 1, pack_exp(1, 0, 0, 0, 0, 'h2C8));
      look_model("R9 slot0 survives", 0, 0, 0);

      // full table: rotating replacement 0 then 1 (R10)
      fill(201, 1, 'h2C9, 5'b01111);
      look("R10 slot0 evicted", 0, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look_model("R10 slot1 still", 1, 0, 0);
      fill(202, 1, 'h2CA, 5'b11111);
      look("R10 slot1 evicted", 1, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look_model("R10 slot2 still", 2, 0, 0);
      look("R10 new page", 202, 1, 2, 1, pack_exp(1, 0, 1, 0, 0, 'h2CA));

      // second process, then per-process invalidate (R12 R2)
      fill(7, 2, 'h077, 5'b01111);
      look("R2 same vpn other pid", 7, 2, 0, 0, pack_exp(1, 0, 0, 0, 0, 'h077));
      inval(1, 0, 1);
      look("R12 pid1 gone a", 5, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look("R12 pid1 gone b", 200, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look("R12 pid1 gone c", 7, 1, 0, 0, pack_exp(0, 2'd1, 0, 0, 0, 0));
      look("R12 pid2 kept", 7, 2, 0, 0, pack_exp(1, 0, 0, 1, 0, 'h077));

      @(posedge clk); #1;
      check("R1 idle after lookups", {30'b0, rs_valid, rs_hit}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule